// File: doc/BRIEF.md
# Streamed 4x4 Matrix Multiplier

The block multiplies two 4x4 matrices of 16-bit signed integers and returns their 4x4 product. Both operands enter as one flat stream of words on a valid/ready input: the sixteen elements of the left operand A, then the sixteen elements of the right operand B. Each matrix is sent row-major, so flat index k is row k/4, column k%4. The product C = A x B leaves on a valid/ready output as sixteen flat row-major words. The sixteenth word carries a last marker. Each output word is 34 bits wide, which holds the exact sum of four full-scale products.

A small state machine sequences one operation at a time. In `ST_LOAD` the block accepts input words and counts them. The 32nd accepted word moves it to `ST_COMPUTE`. In that state a fully parallel array forms all sixteen dot products in one cycle and latches them, and the machine always moves on to `ST_DRAIN`. `ST_DRAIN` streams the latched results. When the 16th result is accepted downstream, the machine returns to `ST_LOAD`. Input ready is high only in `ST_LOAD`, so a new operation cannot overlap the drain of the previous one.

Top module: `mat4_stream_mul`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1, `out_valid` is 0 and `out_last` is 0.
- R2: Input words are counted only on cycles with `in_valid` and `in_ready` both high. Accepted words 0..15 are A and words 16..31 are B. Within each matrix, word k is row k/4, column k%4. Words offered with `in_valid` low are ignored.
- R3: Result element (i,j) equals the exact signed sum over k of A(i,k)*B(k,j), given as 34-bit two's complement. This holds for full-scale operands, including all elements at -32768.
- R4: The sixteen results leave in row-major order: word m is C(m/4, m%4).
- R5: `out_last` is 1 on the 16th result word and 0 on every other word, and it is never 1 while `out_valid` is 0.
- R6: The output word index advances only on a cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R7: From the cycle after the 32nd input word is accepted until the 16th result is accepted, `in_ready` is 0. `in_ready` and `out_valid` are never 1 in the same cycle.
- R8: `out_valid` first rises at the second rising edge after the edge that accepts the 32nd input word.
- R9: A reset during loading discards the partially received operands. The next operation takes a fresh 32 words.
- R10: Operations can run back to back. After the last result is accepted, `in_ready` returns to 1 on the next cycle and a new operation is computed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 16 | Signed operand element, A then B, row-major |
| out_valid | output | 1 | Result word is offered |
| out_ready | input | 1 | Downstream accepts the result word |
| out_data | output | 34 | Signed result element, row-major |
| out_last | output | 1 | Marks the 16th result word |

## Verification
The bench uses asymmetric operands, so swapping A and B, or reading rows as columns, produces wrong products. A design that transposed the index mapping or mixed up the operand order would therefore fail the comparison.

Full-scale negative operands produce a result of 2^32. A result path narrower than 34 bits, or one that loses sign extension, would return a wrong value there.

The bench checks the result stream in three ways:
- It applies irregular backpressure and checks that every held word stays stable. A design that advanced its index without a handshake would skip or repeat words.
- It samples `out_valid` and `in_ready` around the 32nd input word to catch an off-by-one in the latency or in the word count.
- It resets in the middle of loading. A design that kept its stale count would then misalign A and B.

// File: rtl/mat4_pkg.sv
package mat4_pkg;
    parameter int IN_W  = 16;
    parameter int DIM   = 4;
    localparam int NE    = DIM * DIM;
    localparam int OUT_W = 2 * IN_W + $clog2(DIM);
    localparam int CNT_W = $clog2(2 * NE);
    localparam int OIX_W = $clog2(NE);

    typedef logic [NE-1:0][IN_W-1:0]  in_mat_t;
    typedef logic [NE-1:0][OUT_W-1:0] out_mat_t;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_COMPUTE = 2'd1,
        ST_DRAIN   = 2'd2
    } mm_state_t;
endpackage

// File: rtl/mat4_operand_buf.sv
module mat4_operand_buf
    import mat4_pkg::*;
(
    input  logic             clk,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_idx,
    input  logic [IN_W-1:0]  wr_data,
    output in_mat_t          a_flat,
    output in_mat_t          b_flat
);
    // Top bit of the word count selects the operand; lower bits give the flat index.
    localparam int SEL_BIT = CNT_W - 1;

    in_mat_t a_q, b_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_idx[SEL_BIT]) begin
                b_q[wr_idx[SEL_BIT-1:0]] <= wr_data;
            end else begin
                a_q[wr_idx[SEL_BIT-1:0]] <= wr_data;
            end
        end
    end

    assign a_flat = a_q;
    assign b_flat = b_q;
endmodule

// File: rtl/mat4_mac_array.sv
module mat4_mac_array
    import mat4_pkg::*;
(
    input  in_mat_t  a_flat,
    input  in_mat_t  b_flat,
    output out_mat_t c_flat
);
    // One dot-product unit per result element, all evaluated concurrently.
    for (genvar gi = 0; gi < DIM; gi++) begin : g_row
        for (genvar gj = 0; gj < DIM; gj++) begin : g_col
            logic signed [2*IN_W-1:0] prod [DIM];
            logic signed [OUT_W-1:0]  acc;

            always_comb begin
                acc = '0;
                for (int k = 0; k < DIM; k++) begin
                    prod[k] = $signed(a_flat[gi*DIM + k]) * $signed(b_flat[k*DIM + gj]);
                    acc = acc + OUT_W'(prod[k]);
                end
            end

            assign c_flat[gi*DIM + gj] = acc;
        end
    end
endmodule

// File: rtl/mat4_result_stream.sv
module mat4_result_stream
    import mat4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  out_mat_t         c_flat,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last,
    output logic             done
);
    localparam logic [OIX_W-1:0] LAST_IX = OIX_W'(NE - 1);

    out_mat_t         res_q;
    logic [OIX_W-1:0] oix_q;
    logic             vld_q;
    logic             fire;

    assign fire = vld_q && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            oix_q <= '0;
        end else if (load) begin
            res_q <= c_flat;
            vld_q <= 1'b1;
            oix_q <= '0;
        end else if (fire) begin
            if (oix_q == LAST_IX) begin
                vld_q <= 1'b0;
                oix_q <= '0;
            end else begin
                oix_q <= oix_q + 1'b1;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_data  = res_q[oix_q];
    assign out_last  = vld_q && (oix_q == LAST_IX);
    assign done      = fire && (oix_q == LAST_IX);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_index_R6: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(oix_q));

    assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
endmodule

// File: rtl/mat4_stream_mul.sv
module mat4_stream_mul
    import mat4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last
);
    localparam logic [CNT_W-1:0] LAST_IN = CNT_W'(2 * NE - 1);

    mm_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept, accept_last, load_res, drain_done;
    in_mat_t          a_flat, b_flat;
    out_mat_t         c_flat;

    assign accept      = in_valid && in_ready;
    assign accept_last = accept && (cnt_q == LAST_IN);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOAD;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:    if (accept_last) state_d = ST_COMPUTE;
            ST_COMPUTE: state_d = ST_DRAIN;
            ST_DRAIN:   if (drain_done)  state_d = ST_LOAD;
            default:    state_d = ST_LOAD;
        endcase
    end

    // State outputs
    always_comb begin
        in_ready = 1'b0;
        load_res = 1'b0;
        unique case (state_q)
            ST_LOAD:    in_ready = 1'b1;
            ST_COMPUTE: load_res = 1'b1;
            ST_DRAIN:   ;
            default:    ;
        endcase
    end

    // Input word counter: wraps to zero after the 32nd word
    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (accept) cnt_q <= cnt_q + 1'b1;
    end

    mat4_operand_buf u_buf (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (cnt_q),
        .wr_data (in_data),
        .a_flat  (a_flat),
        .b_flat  (b_flat)
    );

    mat4_mac_array u_mac (
        .a_flat (a_flat),
        .b_flat (b_flat),
        .c_flat (c_flat)
    );

    mat4_result_stream u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load_res),
        .c_flat    (c_flat),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .done      (drain_done)
    );

    assert_ready_drops_R7: assert property (@(posedge clk) disable iff (rst)
        accept_last |=> !in_ready);

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        accept_last |=> ##1 out_valid);

    assert_reload_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> in_ready);
endmodule

// File: tb/mat4_stream_mul_test.sv
`timescale 1ns/1ps
module mat4_stream_mul_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [33:0] out_data;
    logic        out_last;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int ma [16];
    int mb [16];
    longint mc [16];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    mat4_stream_mul uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compute_ref();
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                mc[i*4+j] = 0;
                for (int k = 0; k < 4; k++)
                    mc[i*4+j] += longint'(ma[i*4+k]) * longint'(mb[k*4+j]);
            end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drives one word; gaps put garbage on in_data with in_valid low (R2)
    task automatic push_word(input int v, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0; in_data = 16'hDEAD;
        end
        @(negedge clk);
        in_valid = 1'b1; in_data = v[15:0];
        while (!in_ready) @(negedge clk);
    endtask

    // Sends A and B; checks R7/R8 timing around the 32nd word
    task automatic send_op(input int gap_mode);
        for (int w = 0; w < 32; w++)
            push_word(w < 16 ? ma[w] : mb[w-16], (gap_mode != 0 && (w % 3) == 1) ? 2 : 0);
        @(negedge clk);
        in_valid = 1'b0; in_data = 16'hBEEF;
        check("R7 ready low after 32nd word", in_ready, 0);
        check("R8 valid not yet after one edge", out_valid, 0);
        @(negedge clk);
        check("R8 valid after two edges", out_valid, 1);
    endtask

    // Receives 16 results, compares R3/R4/R5, checks hold under stall (R6)
    task automatic recv_op(input int stall_mode);
        int k = 0;
        logic [33:0] held = '0;
        logic was_stalled = 1'b0;
        int spin = 0;
        while (k < 16 && spin < 400) begin
            logic rdy;
            @(negedge clk);
            spin++;
            rdy = (stall_mode == 0) ? 1'b1 : (((spin * 7) % 5) < 2);
            if (was_stalled) check("R6 data held under stall", out_data, held);
            out_ready = rdy;
            if (out_valid) begin
                check("R7 ready low while draining", in_ready, 0);
                if (rdy) begin
                    check("R3 R4 result element", longint'($signed(out_data)), mc[k]);
                    check("R5 last flag", out_last, (k == 15));
                    k++;
                    was_stalled = 1'b0;
                end else begin
                    held = out_data;
                    was_stalled = 1'b1;
                end
            end else begin
                check("R5 last only with valid", out_last, 0);
            end
        end
        check("R6 sixteen words received", k, 16);
        @(negedge clk);
        out_ready = 1'b0;
        check("R10 ready returns after drain", in_ready, 1);
        check("R6 no extra word", out_valid, 0);
    endtask

    task automatic test_reset_state();
        do_reset();
        check("R1 in_ready after reset", in_ready, 1);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 out_last after reset", out_last, 0);
    endtask

    task automatic test_asym();
        for (int e = 0; e < 16; e++) begin ma[e] = e + 1; mb[e] = (e * 5 + 3) % 11 - 5; end
        compute_ref();
        send_op(0);
        recv_op(0);
    endtask

    task automatic test_full_scale();
        for (int e = 0; e < 16; e++) begin ma[e] = -32768; mb[e] = -32768; end
        compute_ref();
        send_op(1);
        recv_op(1);
        for (int e = 0; e < 16; e++) begin
            ma[e] = (e % 2) ? 32767 : -32768;
            mb[e] = (e % 3) ? -32768 : 32767;
        end
        compute_ref();
        send_op(0);
        recv_op(1);
    endtask

    task automatic test_reset_midload();
        for (int w = 0; w < 10; w++) push_word(1000 + w, 0);
        do_reset();
        check("R9 ready after mid-load reset", in_ready, 1);
        check("R9 no valid after mid-load reset", out_valid, 0);
        for (int e = 0; e < 16; e++) begin ma[e] = (e * 13) % 17 - 8; mb[e] = 3 - e; end
        compute_ref();
        send_op(1);
        recv_op(0);
    endtask

    task automatic test_back_to_back();
        for (int e = 0; e < 16; e++) begin ma[e] = (e == 0 || e == 5 || e == 10 || e == 15); mb[e] = e * 100 - 700; end
        compute_ref();
        send_op(0);
        recv_op(0);
        for (int e = 0; e < 16; e++) begin ma[e] = 12345 - e * 999; mb[e] = (e * 37) % 29 - 14; end
        compute_ref();
        send_op(0);
        recv_op(1);
    endtask

    initial begin
        fork
            begin
                test_reset_state();
                test_asym();
                test_full_scale();
                test_reset_midload();
                test_back_to_back();
            end
            begin
                wait (cyc >= 100000);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule